// File: doc/BRIEF.md
# Line Voltage Sag Detector

This block watches a signed voltage sample stream and keeps the largest magnitude seen in each half line cycle. A strobe from an external zero-crossing detector marks the end of every half cycle. At each strobe the captured peak, reduced to an 8-bit level, is compared with a programmable threshold. A programmable number of consecutive half cycles below that threshold raises a level-sensitive sag output. The first half cycle whose peak is at or above the threshold clears it again.

Two 8-bit settings are loaded through a small write port: the threshold level and the number of half cycles needed to qualify a sag. A one-clock event pulse marks each new sag, so an interrupt controller can latch it without tracking the level itself.

Top module: `sag_detector`

## Requirements
- R1: After reset `sag` and `sag_event` are 0, the threshold is 0 and the half-cycle count setting is 0xFF.
- R2: The peak is the largest magnitude of the valid samples since the previous strobe, and the most negative code saturates to the largest positive magnitude. The level compared is magnitude bits [14:7] (for SAMPLE_W=16). A sample that is valid in the strobe cycle belongs to the new half cycle, and the peak restarts from zero at every strobe.
- R3: A half cycle is "below" when its peak level is strictly less than the threshold. Each below half cycle adds one to a consecutive counter. `sag` rises at the strobe where the counter reaches the count setting, and a setting of 0 behaves like 1.
- R4: A half cycle whose peak level is at or above the threshold zeroes the counter and drops `sag` at that strobe.
- R5: `sag` changes only on the clock edge that samples a strobe or a configuration write.
- R6: `sag_event` is high for exactly one clock, in the cycle after `sag` rises, and never otherwise.
- R7: A write with `cfg_addr`=0 loads the threshold, and `cfg_addr`=1 loads the count setting. Any write zeroes the counter and drops `sag`. A write takes priority over a strobe in the same cycle.
- R8: The counter saturates at 255, so with a count setting of 255 `sag` rises at the 255th below half cycle and stays high after it.
- R9: With a threshold of 0 no half cycle is below, and `sag` never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_valid | input | 1 | Sample qualifier |
| sample | input | SAMPLE_W | Signed voltage sample |
| half_strobe | input | 1 | End of a half line cycle |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 1 | 0 = threshold, 1 = half-cycle count |
| cfg_wdata | input | LVL_W | Write data |
| sag | output | 1 | Sag present |
| sag_event | output | 1 | One-clock pulse on a new sag |

## Verification
Every result is due one clock after its cause. `sag` follows the edge that samples the strobe or the write, and `sag_event` is visible in the same cycle as the new `sag`. The peak of a half cycle counts only through the `sag` decision made at its closing strobe. The bench drives inputs on falling edges and reads outputs on the falling edge after the edge that takes the strobe, so each check falls inside the single cycle in which its answer is defined.

// File: rtl/sag_detector.sv
module sag_detector #(
  parameter int SAMPLE_W = 16,
  parameter int LVL_W    = 8,
  parameter int CNT_W    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sample_valid,
  input  logic [SAMPLE_W-1:0] sample,
  input  logic                half_strobe,
  input  logic                cfg_we,
  input  logic                cfg_addr,
  input  logic [LVL_W-1:0]    cfg_wdata,
  output logic                sag,
  output logic                sag_event
);
  localparam int              TOP     = SAMPLE_W - 2;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [SAMPLE_W-1:0] MOST_NEG = {1'b1, {(SAMPLE_W-1){1'b0}}};
  localparam logic [SAMPLE_W-1:0] MOST_POS = {1'b0, {(SAMPLE_W-1){1'b1}}};

  logic [SAMPLE_W-1:0] mag, peak_q;
  logic [LVL_W-1:0]    lvl_q, peak_lvl;
  logic [CNT_W-1:0]    cyc_q, cnt_q, cnt_inc;
  logic                sag_q, below;

  assign mag      = !sample[SAMPLE_W-1] ? sample :
                    (sample == MOST_NEG) ? MOST_POS : (~sample + 1'b1);
  assign peak_lvl = peak_q[TOP -: LVL_W];
  assign below    = peak_lvl < lvl_q;
  assign cnt_inc  = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
  assign sag_event = sag & ~sag_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      peak_q <= '0;
    else if (half_strobe)
      peak_q <= sample_valid ? mag : '0;
    else if (sample_valid && mag > peak_q)
      peak_q <= mag;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q <= '0;
      cyc_q <= '1;
      cnt_q <= '0;
      sag   <= 1'b0;
      sag_q <= 1'b0;
    end else begin
      sag_q <= sag;
      if (cfg_we) begin
        if (cfg_addr) cyc_q <= cfg_wdata[CNT_W-1:0];
        else          lvl_q <= cfg_wdata;
        cnt_q <= '0;
        sag   <= 1'b0;
      end else if (half_strobe) begin
        if (below) begin
          cnt_q <= cnt_inc;
          sag   <= cnt_inc >= cyc_q;
        end else begin
          cnt_q <= '0;
          sag   <= 1'b0;
        end
      end
    end
  end

  AST_EVENT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    sag_event |=> !sag_event); // R6
  AST_SAG_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !half_strobe && !cfg_we |=> $stable(sag)); // R5
  AST_CFG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> !sag && cnt_q == '0); // R7
  AST_RECOVER: assert property (@(posedge clk) disable iff (!rst_n)
    half_strobe && !cfg_we && !below |=> !sag && cnt_q == '0); // R4
  AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    half_strobe && !cfg_we && below && cnt_q == CNT_MAX |=> cnt_q == CNT_MAX); // R8
  AST_ZERO_LVL: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_q == '0 |-> !below); // R9
endmodule

// File: tb/sag_detector_tb.sv
module sag_detector_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sample_valid = 1'b0;
  logic [15:0] sample = '0;
  logic half_strobe = 1'b0;
  logic cfg_we = 1'b0;
  logic cfg_addr = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic sag, sag_event;
  int runs = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sag_detector u_dut (
    .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .sample(sample),
    .half_strobe(half_strobe), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .sag(sag), .sag_event(sag_event)
  );

  // {sample, expected sag, expected event}; threshold 0x40, count 3
  localparam logic [17:0] VEC [10] = '{
    {16'h1000, 1'b0, 1'b0}, {16'hF000, 1'b0, 1'b0}, {16'h0100, 1'b1, 1'b1},
    {16'h0000, 1'b1, 1'b0}, {16'h2000, 1'b0, 1'b0}, {16'hE001, 1'b0, 1'b0},
    {16'h1FFF, 1'b0, 1'b0}, {16'hF000, 1'b1, 1'b1}, {16'h8000, 1'b0, 1'b0},
    {16'h1000, 1'b0, 1'b0}
  };

  task automatic check(input string req, input logic got, input logic exp);
    runs++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b", req, got, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic put(input logic [15:0] s);
    @(negedge clk); sample_valid = 1'b1; sample = s;
    @(negedge clk); sample_valid = 1'b0;
  endtask

  task automatic strobe();
    @(negedge clk); half_strobe = 1'b1;
    @(negedge clk); half_strobe = 1'b0;
  endtask

  initial begin
    #2ms;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hung expected finish");
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 sag", sag, 1'b0);
    check("R1 event", sag_event, 1'b0);
    // R9: reset threshold 0, nothing is below
    repeat (3) strobe();
    check("R9 zero threshold", sag, 1'b0);
    // R1: count setting defaults to 255, three below halves not enough
    wr(1'b0, 8'h40);
    repeat (3) begin put(16'h0010); strobe(); end
    check("R1 default count", sag, 1'b0);

    wr(1'b1, 8'd3);
    for (int i = 0; i < 10; i++) begin
      put(VEC[i][17:2]);
      strobe();
      check("R3/R4 table sag", sag, VEC[i][1]);
      check("R6 table event", sag_event, VEC[i][0]);
    end
    @(negedge clk);
    check("R6 event one clock", sag_event, 1'b0);

    // R2: multi-sample peak, largest wins
    wr(1'b1, 8'd1);
    put(16'h0100); put(16'h3000); put(16'h0200); strobe();
    check("R2 max of samples", sag, 1'b0);
    // R2: peak cleared, empty half is below
    strobe();
    check("R2 peak cleared", sag, 1'b1);
    // R2: sample in strobe cycle starts new half
    @(negedge clk); half_strobe = 1'b1; sample_valid = 1'b1; sample = 16'h3000;
    @(negedge clk); half_strobe = 1'b0; sample_valid = 1'b0;
    check("R2 strobe sample excluded", sag, 1'b1);
    strobe();
    check("R2 strobe sample in next half", sag, 1'b0);

    // R7: write clears sag and restarts counter
    wr(1'b1, 8'd2);
    strobe(); strobe();
    check("R7 setup", sag, 1'b1);
    wr(1'b0, 8'h40);
    check("R7 write drops sag", sag, 1'b0);
    strobe();
    check("R7 counter restarted", sag, 1'b0);
    // R5: sag holds with no strobe
    repeat (4) put(16'h7000);
    check("R5 holds between strobes", sag, 1'b0);
    strobe();
    check("R5 recover at strobe", sag, 1'b0);
    // R7: write wins over strobe
    wr(1'b1, 8'd1);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = 1'b1; cfg_wdata = 8'd1; half_strobe = 1'b1;
    @(negedge clk); cfg_we = 1'b0; half_strobe = 1'b0;
    check("R7 write priority", sag, 1'b0);
    // R3: count 0 acts as 1
    wr(1'b1, 8'd0);
    strobe();
    check("R3 zero count", sag, 1'b1);

    // R8: saturation with count 255
    wr(1'b1, 8'd255);
    for (int k = 1; k <= 260; k++) begin
      strobe();
      if (k == 254) check("R8 before 255", sag, 1'b0);
      if (k == 255) begin
        check("R8 at 255", sag, 1'b1);
        check("R6 event at 255", sag_event, 1'b1);
      end
    end
    check("R8 stays high", sag, 1'b1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule